// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Up/Down Counter

This block is a 16-bit counter that counts up or down and is reached over an 8-bit register bus. The counter is split into a low byte and a high byte. The bus never touches the live high byte directly. Instead, an 8-bit holding register sits between the bus and the upper half of the counter. This lets software read or write the whole 16-bit value coherently with two byte transfers, even while the counter keeps moving.

The counter changes only when a tick arrives. A 3-bit tick-select register chooses the tick source: no tick at all, every clock, one of four prescaler divisions, or an edge of an external input. On each tick the counter is cleared, stepped up by one, stepped down by one, or held, according to plain control pins. Two flags are combinational: one shows that the count equals a programmable TOP value, the other shows that the count is zero. A registered one-cycle pulse marks the upward wrap from 0xFFFF to 0x0000.

The bus uses single-cycle strobes and has no back-pressure. A write strobe is accepted on the rising edge where it is high. Read data appears combinationally in the same cycle as the read strobe, and is zero when no read is active. No data stream passes through the block, so no valid/ready handshake is used.

Top module: `bytecnt16`

## Requirements
- R1: The bus addresses are fixed. Address 0 reads the live count bits 7:0. Address 1 reads the holding register. Address 2 reads and writes the tick-select field in data bits 2:0, and reads return zero in bits 7:3. When no read strobe is active, read data is zero.
- R2: A read of address 0 copies the live count bits 15:8 into the holding register on the same clock edge. A later read of address 1 returns that copy, not the current live high byte.
- R3: A write to address 1 loads only the holding register and leaves the count unchanged.
- R4: A write to address 0 loads the count with the holding register in bits 15:8 and the bus data in bits 7:0, on that edge.
- R5: On a tick, the count has the following priority: clear input high gives 0; otherwise, with count-enable high, it becomes count+1 when the direction input is 0, or count-1 when it is 1; with count-enable low it holds.
- R6: The tick-select codes are: 0 none, 1 every clock, 2 every 8th clock, 3 every 64th, 4 every 256th, 5 every 1024th, 6 falling edge of the external input, 7 rising edge of the external input. The prescaler runs freely from reset, so any window of k·N clocks under division N gives exactly k ticks.
- R7: With tick select 0, the count holds whatever the clear, enable and direction inputs do.
- R8: A bus write to address 0 on an edge takes priority over a clear or a step on that same edge.
- R9: Stepping up from 0xFFFF gives 0x0000 and raises the overflow output for exactly one cycle. Stepping down from 0x0000 gives 0xFFFF and raises no overflow.
- R10: The TOP flag is high exactly when the count equals the TOP input. The BOTTOM flag is high exactly when the count is zero.
- R11: Reset clears the count, the holding register and the tick-select field to zero. During reset the overflow output is low.
- R12: The external input passes through a two-flop synchronizer and an edge detector. Each selected edge that lasts several clocks produces exactly one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 2 | Byte address (0 low count, 1 holding register, 2 tick select) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational, zero when idle |
| ext_tick_i | input | 1 | Asynchronous external tick source |
| cnt_en_i | input | 1 | Step on tick when high |
| cnt_down_i | input | 1 | Direction: 0 up, 1 down |
| cnt_clr_i | input | 1 | Clear on tick |
| top_val_i | input | 16 | Value compared for the TOP flag |
| at_top_o | output | 1 | Count equals top_val_i |
| at_bottom_o | output | 1 | Count is zero |
| ovf_o | output | 1 | One-cycle pulse on the upward wrap |

## Verification
Some rules are checked by assertions on every cycle:
- a low-byte write wins over counting;
- the count stays still when there is no tick and no write;
- an upward step adds exactly one;
- the overflow pulse only appears with a zero count;
- a low-byte read captures the live high byte;
- tick select 0 never produces a tick.

Other behaviour can only be shown by the bench's scenarios:
- the prescaler ratios, observed as exact tick counts over aligned windows;
- the external-edge counting through the synchronizer;
- the coherence of a 16-bit read taken while the count carries across the byte boundary;
- the wrap values in both directions.

// File: rtl/bytecnt_pkg.sv
package bytecnt_pkg;
  typedef enum logic [1:0] {
    ADR_LO  = 2'd0,
    ADR_HI  = 2'd1,
    ADR_SEL = 2'd2,
    ADR_RSV = 2'd3
  } adr_e;

  typedef enum logic [2:0] {
    TS_OFF      = 3'd0,
    TS_DIV1     = 3'd1,
    TS_DIV8     = 3'd2,
    TS_DIV64    = 3'd3,
    TS_DIV256   = 3'd4,
    TS_DIV1024  = 3'd5,
    TS_EXT_FALL = 3'd6,
    TS_EXT_RISE = 3'd7
  } tsel_e;
endpackage

// File: rtl/bytecnt_tick.sv
module bytecnt_tick
  import bytecnt_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  tsel_e sel_i,
  input  logic  ext_i,
  output logic  tick_o
);
  localparam int NDIV = 4;

  logic [PRE_W-1:0] pre_q;
  logic [NDIV-1:0]  div_hit;
  logic             sync1_q, sync2_q, prev_q;
  logic             ext_rise, ext_fall;

  // free-running prescaler, never cleared except by reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  // a division by 2^SH fires when the low SH bits are all ones
  for (genvar g = 0; g < NDIV; g++) begin : g_div
    localparam int SH = (g == 0) ? 3 : (g == 1) ? 6 : (g == 2) ? 8 : PRE_W;
    assign div_hit[g] = &pre_q[SH-1:0];
  end

  // two-flop synchronizer plus one stage for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= ext_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign ext_rise = sync2_q & ~prev_q;
  assign ext_fall = ~sync2_q & prev_q;

  always_comb begin
    unique case (sel_i)
      TS_OFF:      tick_o = 1'b0;
      TS_DIV1:     tick_o = 1'b1;
      TS_DIV8:     tick_o = div_hit[0];
      TS_DIV64:    tick_o = div_hit[1];
      TS_DIV256:   tick_o = div_hit[2];
      TS_DIV1024:  tick_o = div_hit[3];
      TS_EXT_FALL: tick_o = ext_fall;
      TS_EXT_RISE: tick_o = ext_rise;
      default:     tick_o = 1'b0;
    endcase
  end

  // R7: a stopped selection produces no tick
  assert_off_no_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == TS_OFF) |-> !tick_o);
endmodule

// File: rtl/bytecnt_core.sv
module bytecnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             down_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] top_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_top_o,
  output logic             at_bottom_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  // priority: bus load, then clear, then step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (tick_i) begin
        if (clr_i) begin
          cnt_q <= '0;
        end else if (en_i) begin
          if (down_i) begin
            cnt_q <= cnt_q - ONE;
          end else begin
            cnt_q <= cnt_q + ONE;
            ovf_q <= (cnt_q == MAX);
          end
        end
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign ovf_o       = ovf_q;
  assign at_top_o    = (cnt_q == top_val_i);
  assign at_bottom_o = (cnt_q == '0);

  assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));

  assert_step_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !clr_i && en_i && !down_i) |=> (cnt_q == $past(cnt_q) + ONE));

  assert_ovf_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (cnt_q == '0));
endmodule

// File: rtl/bytecnt_regs.sv
module bytecnt_regs
  import bytecnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W/2-1:0] rdata_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output tsel_e            sel_o
);
  localparam int BYTE_W = CNT_W / 2;

  logic [BYTE_W-1:0] temp_q;
  tsel_e             sel_q;
  logic              rd_lo, wr_lo, wr_hi, wr_sel;

  assign rd_lo  = rd_i && (addr_i == ADR_LO);
  assign wr_lo  = wr_i && (addr_i == ADR_LO);
  assign wr_hi  = wr_i && (addr_i == ADR_HI);
  assign wr_sel = wr_i && (addr_i == ADR_SEL);

  // holding register: filled by a high-byte write or a low-byte read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q <= '0;
      sel_q  <= TS_OFF;
    end else begin
      if (wr_hi)      temp_q <= wdata_i;
      else if (rd_lo) temp_q <= cnt_i[CNT_W-1:BYTE_W];
      if (wr_sel)     sel_q  <= tsel_e'(wdata_i[2:0]);
    end
  end

  assign load_o     = wr_lo;
  assign load_val_o = {temp_q, wdata_i};
  assign sel_o      = sel_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        ADR_LO:  rdata_o = cnt_i[BYTE_W-1:0];
        ADR_HI:  rdata_o = temp_q;
        ADR_SEL: rdata_o[2:0] = sel_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assert_lo_read_captures_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo && !wr_hi) |=> (temp_q == $past(cnt_i[CNT_W-1:BYTE_W])));
endmodule

// File: rtl/bytecnt16.sv
module bytecnt16
  import bytecnt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [CNT_W/2-1:0] bus_wdata_i,
  output logic [CNT_W/2-1:0] bus_rdata_o,
  input  logic               ext_tick_i,
  input  logic               cnt_en_i,
  input  logic               cnt_down_i,
  input  logic               cnt_clr_i,
  input  logic [CNT_W-1:0]   top_val_i,
  output logic               at_top_o,
  output logic               at_bottom_o,
  output logic               ovf_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic             load;
  logic             tick;
  tsel_e            sel;

  bytecnt_regs #(.CNT_W(CNT_W)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .cnt_i      (cnt),
    .rdata_o    (bus_rdata_o),
    .load_o     (load),
    .load_val_o (load_val),
    .sel_o      (sel)
  );

  bytecnt_tick #(.PRE_W(PRE_W)) tick_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .ext_i  (ext_tick_i),
    .tick_o (tick)
  );

  bytecnt_core #(.CNT_W(CNT_W)) core_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .clr_i       (cnt_clr_i),
    .en_i        (cnt_en_i),
    .down_i      (cnt_down_i),
    .load_i      (load),
    .load_val_i  (load_val),
    .top_val_i   (top_val_i),
    .cnt_o       (cnt),
    .at_top_o    (at_top_o),
    .at_bottom_o (at_bottom_o),
    .ovf_o       (ovf_o)
  );
endmodule

// File: tb/bytecnt16_tb_top.sv
module bytecnt16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        ext = 1'b0, en = 1'b0, down = 1'b0, clr = 1'b0;
  logic [15:0] top_val = 16'h0010;
  logic        at_top, at_bottom, ovf;

  int n_total = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bytecnt16 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .ext_tick_i(ext), .cnt_en_i(en), .cnt_down_i(down), .cnt_clr_i(clr),
    .top_val_i(top_val), .at_top_o(at_top), .at_bottom_o(at_bottom), .ovf_o(ovf)
  );

  // {start, down, ticks, expected}
  localparam logic [48:0] VECS [8] = '{
    {16'h0000, 1'b0, 16'd5,  16'h0005},
    {16'h00FE, 1'b0, 16'd3,  16'h0101},
    {16'h0100, 1'b1, 16'd1,  16'h00FF},
    {16'hFFFE, 1'b0, 16'd3,  16'h0001},
    {16'h0001, 1'b1, 16'd2,  16'hFFFF},
    {16'h1234, 1'b1, 16'd16, 16'h1224},
    {16'hABCD, 1'b0, 16'd1,  16'hABCE},
    {16'h8000, 1'b1, 16'd1,  16'h7FFF}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge
  task automatic bw(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic load16(input logic [15:0] v);
    bw(2'd1, v[15:8]);
    bw(2'd0, v[7:0]);
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo, hi;
    br(2'd0, lo);
    br(2'd1, hi);
    v = {hi, lo};
  endtask

  // selection active for exactly n counted edges
  task automatic run_sel(input logic [2:0] s, input int n);
    bw(2'd2, {5'd0, s});
    repeat (n - 1) @(negedge clk);
    bw(2'd2, 8'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    check("R11 ovf in reset", {15'd0, ovf}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    br(2'd0, b); check("R11 count low", {8'd0, b}, 16'h0000);
    br(2'd1, b); check("R11 holding", {8'd0, b}, 16'h0000);
    br(2'd2, b); check("R11 tick select", {8'd0, b}, 16'h0000);
    check("R11 R10 bottom", {15'd0, at_bottom}, 16'd1);
    #1 check("R1 idle rdata", {8'd0, bus_rdata}, 16'd0);

    // vector table, tick select 1
    en = 1'b1;
    foreach (VECS[i]) begin
      load16(VECS[i][48:33]);
      down = VECS[i][32];
      run_sel(3'd1, int'(VECS[i][31:16]));
      read16(v);
      check($sformatf("R5 R9 R4 vector %0d", i), v, VECS[i][15:0]);
    end
    down = 1'b0;

    // R1 R6 select readback
    bw(2'd2, 8'hFD); br(2'd2, b); check("R1 select readback", {8'd0, b}, 16'h0005);
    bw(2'd2, 8'd0);

    // R7 stopped: hold despite enable and clear
    load16(16'h4321);
    repeat (20) @(negedge clk);
    read16(v); check("R7 hold enabled", v, 16'h4321);
    clr = 1'b1; down = 1'b1;
    repeat (10) @(negedge clk);
    read16(v); check("R7 hold clear", v, 16'h4321);
    down = 1'b0;
    // R5 clear on tick
    run_sel(3'd1, 3);
    read16(v); check("R5 clear", v, 16'h0000);
    clr = 1'b0;
    // R5 enable low holds with ticks
    load16(16'h0777); en = 1'b0;
    run_sel(3'd1, 10);
    read16(v); check("R5 enable low", v, 16'h0777);
    en = 1'b1;

    // R3 high write leaves count
    load16(16'h1111);
    bw(2'd1, 8'h77);
    read16(v); check("R3 high write only", v, 16'h1111);

    // R8 write beats step
    bw(2'd2, 8'd1);
    bw(2'd1, 8'h5A); bw(2'd0, 8'hA5);
    br(2'd0, b); check("R8 write over step", {8'd0, b}, 16'h00A5);
    // R8 write beats clear
    clr = 1'b1;
    bw(2'd1, 8'h33); bw(2'd0, 8'h44);
    br(2'd0, b); check("R8 write over clear", {8'd0, b}, 16'h0044);
    br(2'd1, b); check("R2 capture", {8'd0, b}, 16'h0033);
    clr = 1'b0;
    // R2 coherent read across carry
    bw(2'd1, 8'h00); bw(2'd0, 8'hFF);
    read16(v); check("R2 coherent read", v, 16'h00FF);
    bw(2'd2, 8'd0);

    // R9 overflow pulse
    load16(16'hFFFF);
    bw(2'd2, 8'd1);
    @(negedge clk);
    check("R9 ovf pulse", {15'd0, ovf}, 16'd1);
    check("R10 bottom at wrap", {15'd0, at_bottom}, 16'd1);
    @(negedge clk);
    check("R9 ovf one cycle", {15'd0, ovf}, 16'd0);
    bw(2'd2, 8'd0);
    load16(16'h0000); down = 1'b1;
    bw(2'd2, 8'd1);
    @(negedge clk);
    check("R9 no ovf down wrap", {15'd0, ovf}, 16'd0);
    bw(2'd2, 8'd0);
    down = 1'b0;

    // R10 flags
    load16(16'h0010);
    check("R10 top", {14'd0, at_top, at_bottom}, 16'b10);
    load16(16'h0011);
    check("R10 not top", {14'd0, at_top, at_bottom}, 16'b00);

    // R6 prescaler ratios
    load16(16'h0000); run_sel(3'd2, 64);   read16(v); check("R6 div8", v, 16'd8);
    load16(16'h0000); run_sel(3'd3, 128);  read16(v); check("R6 div64", v, 16'd2);
    load16(16'h0000); run_sel(3'd4, 512);  read16(v); check("R6 div256", v, 16'd2);
    load16(16'h0000); run_sel(3'd5, 1024); read16(v); check("R6 div1024", v, 16'd1);

    // R12 external edges
    for (int m = 0; m < 2; m++) begin
      load16(16'h0000);
      bw(2'd2, (m == 0) ? 8'd7 : 8'd6);
      for (int k = 0; k < 5; k++) begin
        ext = 1'b1; repeat (4) @(negedge clk);
        ext = 1'b0; repeat (4) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      bw(2'd2, 8'd0);
      read16(v);
      check((m == 0) ? "R12 rising edges" : "R12 falling edges", v, 16'd5);
    end

    finish_run();
  end
endmodule